// File: doc/BRIEF.md
# Cascaded Masked Interrupt Aggregator

This block gathers interrupt requests on two levels and drives one interrupt line. A 32-bit endpoint group and a 32-bit DMA-completion group each hold pending bits and a mask. Software sets pending bits through a write-one-to-set address and removes them through a write-one-to-clear address. Each group reduces its unmasked pending bits to summary flags. The endpoint group gives one flag for its low half and one for its high half. The DMA group gives one flag for the whole word.

The flags appear at fixed positions of a 32-bit top-level source word. That word also latches two single-cycle event inputs, a timer expiry and a bus-voltage change. It has its own set, clear and mask addresses. A configuration register selects the polarity of the output. The output is forced low while the power-good input is low.

The register interface is a single-cycle word bus. A write takes effect at the next clock edge. Read data is combinational from the current register state.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset, both group source words and both group masks are zero. The top source word and the config register are zero, and the top mask is 0xFFFFFFFF.
- R2: Word addresses are as follows. Endpoint group: 0 source, 1 set, 2 clear, 3 mask. DMA group: 4, 5, 6, 7 in the same order. Top word: 8, 9, 10, 11 in the same order. Config: 12. A write to a set address ORs the data into that source word, and a write to a clear address clears the bits where the data is 1. A write to a source address changes nothing.
- R3: A write to a mask address replaces the mask. The summary flags and the output reflect the new mask in the cycle after the write.
- R4: Top bit 9 is 1 when any endpoint bit in 15:0 is pending with mask bit 0. Top bit 8 is 1 when any endpoint bit in 31:16 is pending with mask bit 0. A mask bit of 1 suppresses its source.
- R5: Top bit 24 is 1 when any DMA-group bit is pending with mask bit 0.
- R6: A high cycle on evt_timer sets top bit 16, and a high cycle on evt_vbus sets top bit 15. An event in the same cycle as a top clear of that bit leaves the bit set.
- R7: Top bits 24, 9 and 8 follow their groups only. Top set and clear writes to these bits have no lasting effect.
- R8: Reads of a source, set or clear address return the current source word of that level, with the summary flags included for the top word. Reads of a mask or of config return the last value written. Any other address reads as zero.
- R9: With config bit 17 = 1, irq_o is high when any top bit is pending with mask bit 0. With config bit 17 = 0, irq_o is high when no top bit is pending with mask bit 0.
- R10: irq_o is low whenever pwr_good is low, whatever the pending state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| evt_timer | input | 1 | Timer-expiry event pulse |
| evt_vbus | input | 1 | Bus-voltage change event pulse |
| pwr_good | input | 1 | Gate; low holds irq_o low |
| irq_o | output | 1 | Interrupt output |

## Verification
The assertions assume that the bus carries at most one write per cycle. Under that assumption a top-level write never coincides with a group write, so a group's flag holds steady across the cycle after a top set. The bench drives exactly one address per cycle, with events and power-good changes applied freely. Random masks are thinned by AND-ing several random words, so that unmasked pending bits, and therefore both output polarities, occur often.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_EP_SRC  = 4'd0;
    localparam logic [ADDR_W-1:0] A_EP_SET  = 4'd1;
    localparam logic [ADDR_W-1:0] A_EP_CLR  = 4'd2;
    localparam logic [ADDR_W-1:0] A_EP_MSK  = 4'd3;
    localparam logic [ADDR_W-1:0] A_DMA_SRC = 4'd4;
    localparam logic [ADDR_W-1:0] A_DMA_SET = 4'd5;
    localparam logic [ADDR_W-1:0] A_DMA_CLR = 4'd6;
    localparam logic [ADDR_W-1:0] A_DMA_MSK = 4'd7;
    localparam logic [ADDR_W-1:0] A_TOP_SRC = 4'd8;
    localparam logic [ADDR_W-1:0] A_TOP_SET = 4'd9;
    localparam logic [ADDR_W-1:0] A_TOP_CLR = 4'd10;
    localparam logic [ADDR_W-1:0] A_TOP_MSK = 4'd11;
    localparam logic [ADDR_W-1:0] A_CFG     = 4'd12;

    // Bit positions inside the top-level source word and config
    localparam int BIT_DMA_SUM = 24;
    localparam int BIT_POL     = 17;
    localparam int BIT_TIMER   = 16;
    localparam int BIT_VBUS    = 15;
    localparam int BIT_EP_LO   = 9;
    localparam int BIT_EP_HI   = 8;
endpackage

// File: rtl/irqc_group.sv
module irqc_group #(
    parameter int W      = 32,
    parameter int SLICES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic              wr_msk,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      src_o,
    output logic [W-1:0]      msk_o,
    output logic [SLICES-1:0] sum_o
);
    localparam int SL_W = W / SLICES;

    typedef struct packed {
        logic [W-1:0] src;
        logic [W-1:0] msk;
    } grp_st_t;

    grp_st_t st_d, st_q;
    logic [W-1:0] pend;

    always_comb begin
        st_d = st_q;
        if (wr_set) st_d.src = st_q.src | wdata;
        if (wr_clr) st_d.src = st_q.src & ~wdata;
        if (wr_msk) st_d.msk = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend  = st_q.src & ~st_q.msk;
    assign src_o = st_q.src;
    assign msk_o = st_q.msk;

    generate
        for (genvar s = 0; s < SLICES; s++) begin : g_slice
            assign sum_o[s] = |pend[s*SL_W +: SL_W];
        end
    endgenerate

    a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((src_o & $past(wdata)) == $past(wdata)));
    a_r2_clr_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((src_o & $past(wdata)) == '0));
    a_r2_src_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_set && !wr_clr) |=> $stable(src_o));
    a_r3_mask_replaces: assert property (@(posedge clk) disable iff (!rst_n)
        wr_msk |=> (msk_o == $past(wdata)));
endmodule

// File: rtl/irqc_top_word.sv
module irqc_top_word
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic              wr_msk,
    input  logic              wr_cfg,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        ep_sum,
    input  logic              dma_sum,
    input  logic              evt_timer,
    input  logic              evt_vbus,
    input  logic              pwr_good,
    output logic [DATA_W-1:0] view_o,
    output logic [DATA_W-1:0] msk_o,
    output logic [DATA_W-1:0] cfg_o,
    output logic              irq_o
);
    localparam logic [DATA_W-1:0] SUM_BITS = (DATA_W'(1) << BIT_DMA_SUM)
                                           | (DATA_W'(1) << BIT_EP_LO)
                                           | (DATA_W'(1) << BIT_EP_HI);

    typedef struct packed {
        logic [DATA_W-1:0] src;
        logic [DATA_W-1:0] msk;
        logic [DATA_W-1:0] cfg;
    } top_st_t;

    top_st_t st_d, st_q;
    logic [DATA_W-1:0] evt_v, sum_v, clr_v, set_v;
    logic              pend;

    always_comb begin
        evt_v = '0;
        evt_v[BIT_TIMER] = evt_timer;
        evt_v[BIT_VBUS]  = evt_vbus;
        sum_v = '0;
        sum_v[BIT_DMA_SUM] = dma_sum;
        sum_v[BIT_EP_LO]   = ep_sum[0];
        sum_v[BIT_EP_HI]   = ep_sum[1];
        clr_v = wr_clr ? wdata : '0;
        set_v = wr_set ? wdata : '0;

        st_d = st_q;
        st_d.src = ((st_q.src & ~clr_v) | set_v | evt_v) & ~SUM_BITS;
        if (wr_msk) st_d.msk = wdata;
        if (wr_cfg) st_d.cfg = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.src <= '0;
            st_q.msk <= '1;
            st_q.cfg <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign view_o = st_q.src | sum_v;
    assign msk_o  = st_q.msk;
    assign cfg_o  = st_q.cfg;
    assign pend   = |(view_o & ~st_q.msk);
    assign irq_o  = pwr_good & (st_q.cfg[BIT_POL] ? pend : ~pend);

    a_r10_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |-> !irq_o);
    a_r6_timer_latch: assert property (@(posedge clk) disable iff (!rst_n)
        evt_timer |=> view_o[BIT_TIMER]);
    a_r6_vbus_latch: assert property (@(posedge clk) disable iff (!rst_n)
        evt_vbus |=> view_o[BIT_VBUS]);
    a_r7_set_not_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set && !dma_sum) |=> !view_o[BIT_DMA_SUM]);
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              evt_timer,
    input  logic              evt_vbus,
    input  logic              pwr_good,
    output logic              irq_o
);
    logic [DATA_W-1:0] ep_src, ep_msk, dma_src, dma_msk;
    logic [DATA_W-1:0] top_view, top_msk, cfg;
    logic [1:0]        ep_sum;
    logic              dma_sum;

    irqc_group #(.W(DATA_W), .SLICES(2)) u_ep (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_set (bus_we && bus_addr == A_EP_SET),
        .wr_clr (bus_we && bus_addr == A_EP_CLR),
        .wr_msk (bus_we && bus_addr == A_EP_MSK),
        .wdata  (bus_wdata),
        .src_o  (ep_src),
        .msk_o  (ep_msk),
        .sum_o  (ep_sum)
    );

    irqc_group #(.W(DATA_W), .SLICES(1)) u_dma (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_set (bus_we && bus_addr == A_DMA_SET),
        .wr_clr (bus_we && bus_addr == A_DMA_CLR),
        .wr_msk (bus_we && bus_addr == A_DMA_MSK),
        .wdata  (bus_wdata),
        .src_o  (dma_src),
        .msk_o  (dma_msk),
        .sum_o  (dma_sum)
    );

    // ep_sum[0] is the low half and ep_sum[1] the high half
    irqc_top_word u_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_set    (bus_we && bus_addr == A_TOP_SET),
        .wr_clr    (bus_we && bus_addr == A_TOP_CLR),
        .wr_msk    (bus_we && bus_addr == A_TOP_MSK),
        .wr_cfg    (bus_we && bus_addr == A_CFG),
        .wdata     (bus_wdata),
        .ep_sum    (ep_sum),
        .dma_sum   (dma_sum),
        .evt_timer (evt_timer),
        .evt_vbus  (evt_vbus),
        .pwr_good  (pwr_good),
        .view_o    (top_view),
        .msk_o     (top_msk),
        .cfg_o     (cfg),
        .irq_o     (irq_o)
    );

    // R8 read decode
    always_comb begin
        case (bus_addr)
            A_EP_SRC, A_EP_SET, A_EP_CLR:    bus_rdata = ep_src;
            A_EP_MSK:                        bus_rdata = ep_msk;
            A_DMA_SRC, A_DMA_SET, A_DMA_CLR: bus_rdata = dma_src;
            A_DMA_MSK:                       bus_rdata = dma_msk;
            A_TOP_SRC, A_TOP_SET, A_TOP_CLR: bus_rdata = top_view;
            A_TOP_MSK:                       bus_rdata = top_msk;
            A_CFG:                           bus_rdata = cfg;
            default:                         bus_rdata = '0;
        endcase
    end
endmodule

// File: tb/irq_cascade_ctrl_tb.sv
module irq_cascade_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_we = 0;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        evt_timer = 0, evt_vbus = 0, pwr_good = 1;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_ep, m_epm, m_dma, m_dmam, m_top, m_topm, m_cfg;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_cascade_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_timer(evt_timer),
        .evt_vbus(evt_vbus), .pwr_good(pwr_good), .irq_o(irq_o)
    );

    function automatic logic [31:0] exp_view();
        logic [31:0] v = m_top;
        v[9]  = |(m_ep[15:0]  & ~m_epm[15:0]);
        v[8]  = |(m_ep[31:16] & ~m_epm[31:16]);
        v[24] = |(m_dma & ~m_dmam);
        return v;
    endfunction

    function automatic logic exp_irq();
        logic p = |(exp_view() & ~m_topm);
        return pwr_good & (m_cfg[17] ? p : ~p);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    // One bus cycle: optional write plus optional events, then model update
    task automatic op(input logic we, input logic [3:0] a, input logic [31:0] d,
                      input logic et, input logic ev);
        logic [31:0] evv;
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d; evt_timer = et; evt_vbus = ev;
        @(negedge clk);
        bus_we = 0; evt_timer = 0; evt_vbus = 0;
        if (we) begin
            case (a)
                4'd1:  m_ep   = m_ep | d;
                4'd2:  m_ep   = m_ep & ~d;
                4'd3:  m_epm  = d;
                4'd5:  m_dma  = m_dma | d;
                4'd6:  m_dma  = m_dma & ~d;
                4'd7:  m_dmam = d;
                4'd9:  m_top  = m_top | d;
                4'd10: m_top  = m_top & ~d;
                4'd11: m_topm = d;
                4'd12: m_cfg  = d;
                default: ;
            endcase
        end
        evv = 0; evv[16] = et; evv[15] = ev;
        m_top = (m_top | evv) & ~32'h0100_0300;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd1357);
        m_ep = 0; m_epm = 0; m_dma = 0; m_dmam = 0; m_top = 0; m_topm = '1; m_cfg = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 ep src", 4'd0, 32'h0);
        rd_chk("R1 ep mask", 4'd3, 32'h0);
        rd_chk("R1 dma src", 4'd4, 32'h0);
        rd_chk("R1 dma mask", 4'd7, 32'h0);
        rd_chk("R1 top src", 4'd8, 32'h0);
        rd_chk("R1 top mask", 4'd11, 32'hFFFF_FFFF);
        rd_chk("R1 cfg", 4'd12, 32'h0);
        chk("R9 idle low-polarity irq", irq_o, 1'b1);

        // R2 set / clear / ignored source write
        op(1, 4'd1, 32'h0001_0003, 0, 0);
        rd_chk("R2 ep set", 4'd0, 32'h0001_0003);
        op(1, 4'd2, 32'h0000_0001, 0, 0);
        rd_chk("R2 ep clr", 4'd0, 32'h0001_0002);
        op(1, 4'd0, 32'hFFFF_FFFF, 0, 0);
        rd_chk("R2 src write ignored", 4'd0, 32'h0001_0002);
        rd_chk("R8 read via set addr", 4'd1, 32'h0001_0002);
        rd_chk("R8 read via clr addr", 4'd2, 32'h0001_0002);
        rd_chk("R8 unused addr", 4'd14, 32'h0);

        // R4 half summaries, R3 mask replacement
        rd_chk("R4 both halves", 4'd8, 32'h0000_0300);
        op(1, 4'd3, 32'h0000_FFFF, 0, 0);
        rd_chk("R3 mask readback", 4'd3, 32'h0000_FFFF);
        rd_chk("R4 low half masked", 4'd8, 32'h0000_0100);
        op(1, 4'd3, 32'hFFFF_0000, 0, 0);
        rd_chk("R4 high half masked", 4'd8, 32'h0000_0200);

        // R5 DMA summary
        op(1, 4'd5, 32'h0000_0080, 0, 0);
        rd_chk("R5 dma pending", 4'd8, 32'h0100_0200);
        op(1, 4'd7, 32'h0000_0080, 0, 0);
        rd_chk("R5 dma masked", 4'd8, 32'h0000_0200);

        // R7 summary bits not writable from top
        op(1, 4'd10, 32'h0000_0200, 0, 0);
        rd_chk("R7 clear of summary", 4'd8, 32'h0000_0200);
        op(1, 4'd9, 32'h0100_0000, 0, 0);
        rd_chk("R7 set of summary", 4'd8, 32'h0000_0200);

        // R6 events
        op(0, 4'd0, 0, 1, 0);
        rd_chk("R6 timer event", 4'd8, 32'h0001_0200);
        op(1, 4'd10, 32'h0001_0000, 1, 1);
        rd_chk("R6 event beats clear", 4'd8, 32'h0001_8200);
        op(1, 4'd10, 32'h0001_8000, 0, 0);
        rd_chk("R6 cleared without event", 4'd8, 32'h0000_0200);

        // R9 polarity
        op(1, 4'd11, 32'hFFFF_FDFF, 0, 0);
        #1 chk("R9 low polarity pending", irq_o, 1'b0);
        op(1, 4'd12, 32'h0002_0000, 0, 0);
        rd_chk("R8 cfg readback", 4'd12, 32'h0002_0000);
        chk("R9 high polarity pending", irq_o, 1'b1);
        op(1, 4'd3, 32'hFFFF_FFFF, 0, 0);
        #1 chk("R9 high polarity none", irq_o, 1'b0);
        op(1, 4'd3, 32'h0, 0, 0);

        // R10 gate
        pwr_good = 0;
        #1 chk("R10 gate forces low", irq_o, 1'b0);
        pwr_good = 1;
        #1 chk("R10 gate released", irq_o, 1'b1);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [3:0]  a;
            logic [31:0] d;
            a = 4'($urandom_range(0, 13));
            d = $urandom;
            if (a == 4'd3 || a == 4'd7 || a == 4'd11) d = d & $urandom & $urandom;
            if (a == 4'd12) d = ($urandom_range(0, 1) == 1) ? 32'h0002_0000 : 32'h0;
            if ($urandom_range(0, 7) == 0) pwr_good = ~pwr_good;
            op(1, a, d, ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0));
            rd_chk("R4/R5/R6 random top view", 4'd8, exp_view());
            chk("R9/R10 random irq", irq_o, exp_irq());
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule